// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block is a timer peripheral held in its split configuration: two independent 8-bit up-counters, a low half and a high half. Each half has its own reload register and restarts from that value whenever it wraps past 0xFF. Each half also has its own overflow flag, which stays set until software writes it to 0.

Each half counts either once per system clock, once every twelve system clocks, or once every eighth rising edge of an external clock. The slower rates are single-cycle count enables in the system-clock domain, so every register sits on one clock. The low half runs whenever split operation is selected. The high half also needs the run bit.

A single level-sensitive interrupt request reflects the high flag, and optionally the low flag, under a global enable. Software reaches the counters, reload values, control byte and flags through a simple write strobe and a combinational read port.

Top module: `split_timer`

Register map (3-bit address): 0 control, 1 flags, 2 low counter, 3 high counter, 4 low reload, 5 high reload; addresses 6 and 7 read as 0.
Control bits: 0 high-half run, 1 external-clock select, 2 low-flag interrupt enable, 3 split select, 4 capture enable, 5 interrupt enable, 6 high-half fast clock, 7 low-half fast clock. Flags: bit 0 low overflow, bit 1 high overflow.

## Requirements
- R1: The counters advance only while control bit 3 is 1 and control bit 4 is 0; otherwise both hold their value.
- R2: A half that advances from 0xFF loads its own reload register (address 4 for low, 5 for high) instead of wrapping to 0.
- R3: The high counter (address 3) advances only while control bit 0 is 1; the low counter ignores control bit 0.
- R4: A half whose fast bit (7 low, 6 high) is 1 advances on every clock. With the fast bit 0, it advances once per 12 clocks when control bit 1 is 0, and once per 8 rising edges of ext_clk when control bit 1 is 1.
- R5: A wrap of the low half sets flag bit 0; a wrap of the high half sets flag bit 1.
- R6: irq is 1 exactly when control bit 5 is 1 and either flag bit 1 is 1, or flag bit 0 and control bit 2 are both 1.
- R7: Flags remain set until software writes 0 to them through address 1; no hardware event clears them.
- R8: A write to a counter takes effect on the next clock and overrides that cycle's count, reload and flag set. A flag write of 0 in the same cycle as a wrap leaves the flag set.
- R9: An active-low reset clears both counters, both reload registers, the control byte, both flags and both prescalers, and drives irq to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External clock, sampled and synchronized internally |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check every cycle that:
- a counter reloads after it passes 0xFF;
- the high counter and the gated counters hold still;
- a fast-clocked low half steps by one;
- a set flag survives any cycle without a flag write;
- a wrap is always followed by its flag;
- irq never rises without the enable and a flag.

Only the bench scenarios can show the prescaler ratios as counts over long windows. The same holds for the same-cycle races between software writes and wraps, and for the exact read values after reset and after each sequence.

// File: rtl/split_timer_pkg.sv
`timescale 1ns/1ps
package split_timer_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_FLAGS  = 3'd1;
  localparam logic [AW-1:0] A_LO_CNT = 3'd2;
  localparam logic [AW-1:0] A_HI_CNT = 3'd3;
  localparam logic [AW-1:0] A_LO_RLD = 3'd4;
  localparam logic [AW-1:0] A_HI_RLD = 3'd5;

  typedef struct packed {
    logic lo_fast;
    logic hi_fast;
    logic irq_en;
    logic capture;
    logic split;
    logic lo_irq_en;
    logic ext_sel;
    logic hi_run;
  } ctrl_t;
endpackage

// File: rtl/split_timer_prescale.sv
`timescale 1ns/1ps
module split_timer_prescale #(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic sys_tick,
  output logic ext_tick
);
  localparam int SW = $clog2(SYS_DIV);
  localparam int EW = $clog2(EXT_DIV);
  localparam logic [SW-1:0] SYS_LAST = SW'(SYS_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

  logic [SW-1:0] sys_q, sys_d;
  logic [EW-1:0] ext_q, ext_d;
  logic [2:0]    sync_q, sync_d;
  logic          ext_rise;

  always_comb begin
    sync_d   = {sync_q[1:0], ext_clk};
    ext_rise = sync_q[1] & ~sync_q[2];
    sys_tick = (sys_q == SYS_LAST);
    sys_d    = sys_tick ? '0 : sys_q + 1'b1;
    ext_tick = ext_rise & (ext_q == EXT_LAST);
    ext_d    = ext_q;
    if (ext_rise) ext_d = (ext_q == EXT_LAST) ? '0 : ext_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= '0;
      ext_q  <= '0;
      sync_q <= '0;
    end else begin
      sys_q  <= sys_d;
      ext_q  <= ext_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/split_timer_half.sv
`timescale 1ns/1ps
module split_timer_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic         wrap
);
  logic [W-1:0] cnt_d, rld_d;

  always_comb begin
    wrap  = tick & (&cnt) & ~wr_cnt;
    rld_d = wr_rld ? wdata : rld;
    cnt_d = cnt;
    if (wr_cnt)    cnt_d = wdata;
    else if (tick) cnt_d = (&cnt) ? rld : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      cnt <= cnt_d;
      rld <= rld_d;
    end
  end
endmodule

// File: rtl/split_timer.sv
`timescale 1ns/1ps
module split_timer
  import split_timer_pkg::*;
#(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int NH = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  ctrl_t         ctrl_q, ctrl_d;
  logic [NH-1:0] flags_q, flags_d;
  logic          sys_tick, ext_tick, active;
  logic [NH-1:0] tick_v, wrap_v, fast_v, gate_v, wr_cnt_v, wr_rld_v;
  logic [DW-1:0] cnt_v [NH];
  logic [DW-1:0] rld_v [NH];
  logic [DW-1:0] lo_cnt, hi_cnt, lo_rld, hi_rld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  split_timer_prescale #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV)) u_pre (
    .clk(clk), .rst_n(rst_ni), .ext_clk(ext_clk),
    .sys_tick(sys_tick), .ext_tick(ext_tick)
  );

  assign active = ctrl_q.split & ~ctrl_q.capture;
  assign fast_v = {ctrl_q.hi_fast, ctrl_q.lo_fast};
  assign gate_v = {ctrl_q.hi_run, 1'b1};

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign tick_v[h]   = active & gate_v[h] &
                         (fast_v[h] | (ctrl_q.ext_sel ? ext_tick : sys_tick));
    assign wr_cnt_v[h] = wr_en & (wr_addr == A_LO_CNT + AW'(h));
    assign wr_rld_v[h] = wr_en & (wr_addr == A_LO_RLD + AW'(h));

    split_timer_half #(.W(DW)) u_half (
      .clk(clk), .rst_n(rst_ni), .tick(tick_v[h]),
      .wr_cnt(wr_cnt_v[h]), .wr_rld(wr_rld_v[h]), .wdata(wr_data),
      .cnt(cnt_v[h]), .rld(rld_v[h]), .wrap(wrap_v[h])
    );
  end

  assign lo_cnt = cnt_v[0];
  assign hi_cnt = cnt_v[1];
  assign lo_rld = rld_v[0];
  assign hi_rld = rld_v[1];

  always_comb begin
    ctrl_d  = (wr_en && wr_addr == A_CTRL) ? ctrl_t'(wr_data) : ctrl_q;
    flags_d = wrap_v | ((wr_en && wr_addr == A_FLAGS) ? wr_data[NH-1:0] : flags_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:   rd_data = ctrl_q;
      A_FLAGS:  rd_data = {{(DW-NH){1'b0}}, flags_q};
      A_LO_CNT: rd_data = lo_cnt;
      A_HI_CNT: rd_data = hi_cnt;
      A_LO_RLD: rd_data = lo_rld;
      A_HI_RLD: rd_data = hi_rld;
      default:  rd_data = '0;
    endcase
  end

  assign irq = ctrl_q.irq_en & (flags_q[1] | (flags_q[0] & ctrl_q.lo_irq_en));
endmodule

// File: rtl/split_timer_chk.sv
`timescale 1ns/1ps
module split_timer_chk
  import split_timer_pkg::*;
(
  input logic          clk,
  input logic          rst_ni,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    ctrl,
  input logic [1:0]    flags,
  input logic [7:0]    lo_cnt,
  input logic [7:0]    hi_cnt,
  input logic [7:0]    lo_rld,
  input logic          lo_tick,
  input logic          lo_wrap,
  input logic          hi_wrap,
  input logic          irq
);
  logic lo_wr, hi_wr, flag_wr, run_ok;
  assign lo_wr   = wr_en && wr_addr == A_LO_CNT;
  assign hi_wr   = wr_en && wr_addr == A_HI_CNT;
  assign flag_wr = wr_en && wr_addr == A_FLAGS;
  assign run_ok  = ctrl[3] && !ctrl[4];

  assert_gated_hold_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_ok && !lo_wr) |=> $stable(lo_cnt));

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (lo_tick && lo_cnt == 8'hFF && !lo_wr) |=> (lo_cnt == $past(lo_rld)));

  assert_hi_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl[0] && !hi_wr) |=> $stable(hi_cnt));

  assert_fast_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_ok && ctrl[7] && lo_cnt != 8'hFF && !lo_wr) |=> (lo_cnt == $past(lo_cnt) + 8'd1));

  assert_lo_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    lo_wrap |=> flags[0]);

  assert_hi_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_wrap |=> flags[1]);

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (ctrl[5] && flags != 2'b00));

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (flags != 2'b00 && !flag_wr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind split_timer split_timer_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl(ctrl_q), .flags(flags_q), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
  .lo_rld(lo_rld), .lo_tick(tick_v[0]), .lo_wrap(wrap_v[0]),
  .hi_wrap(wrap_v[1]), .irq(irq)
);

// File: tb/test_split_timer.sv
`timescale 1ns/1ps
module test_split_timer;
  logic       clk = 1'b0;
  logic       rst_n, ext_clk, wr_en, irq;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int checks = 0;
  int failures = 0;

  split_timer i_split_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #4 clk = ~clk;
  initial begin
    ext_clk = 1'b0;
    forever #16 ext_clk = ~ext_clk;
  end

  // kind: 0 write, 1 idle n cycles, 2 read check, 3 irq check; then addr, data, requirement
  localparam int NV = 52;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0,3'd4,8'hFD,4'd2}, {2'd0,3'd2,8'hFE,4'd2}, {2'd0,3'd0,8'h88,4'd4}, // R2 R4 setup
    {2'd2,3'd2,8'hFE,4'd4}, {2'd1,3'd0,8'd1,4'd0},  {2'd2,3'd2,8'hFF,4'd4},
    {2'd2,3'd1,8'h00,4'd5}, {2'd1,3'd0,8'd1,4'd0},  {2'd2,3'd2,8'hFD,4'd2}, // R2 reload
    {2'd2,3'd1,8'h01,4'd5}, {2'd2,3'd3,8'h00,4'd3}, {2'd3,3'd0,8'h00,4'd6}, // R5 R3 R6
    {2'd1,3'd0,8'd1,4'd0},  {2'd0,3'd0,8'h00,4'd1}, {2'd2,3'd2,8'hFF,4'd1}, // R1
    {2'd1,3'd0,8'd3,4'd0},  {2'd2,3'd2,8'hFF,4'd1}, {2'd2,3'd1,8'h01,4'd7}, // R7
    {2'd0,3'd0,8'h98,4'd1}, {2'd1,3'd0,8'd2,4'd0},  {2'd2,3'd2,8'hFF,4'd1}, // R1 capture
    {2'd0,3'd0,8'h20,4'd6}, {2'd3,3'd0,8'h00,4'd6}, {2'd0,3'd0,8'h24,4'd6}, // R6
    {2'd3,3'd0,8'h01,4'd6}, {2'd0,3'd1,8'h00,4'd7}, {2'd2,3'd1,8'h00,4'd7},
    {2'd3,3'd0,8'h00,4'd6}, {2'd0,3'd2,8'h00,4'd3}, {2'd0,3'd5,8'h80,4'd2},
    {2'd0,3'd3,8'hFF,4'd3}, {2'd0,3'd0,8'h48,4'd3}, {2'd1,3'd0,8'd2,4'd0},  // R3
    {2'd2,3'd3,8'hFF,4'd3}, {2'd0,3'd0,8'h69,4'd3}, {2'd2,3'd3,8'hFF,4'd3},
    {2'd1,3'd0,8'd1,4'd0},  {2'd2,3'd3,8'h80,4'd2}, {2'd2,3'd1,8'h02,4'd5},
    {2'd3,3'd0,8'h01,4'd6}, {2'd0,3'd0,8'h00,4'd0}, {2'd0,3'd1,8'h00,4'd0},
    {2'd0,3'd2,8'hFF,4'd8}, {2'd0,3'd0,8'h88,4'd8}, {2'd0,3'd2,8'h10,4'd8}, // R8 write wins
    {2'd2,3'd2,8'h10,4'd8}, {2'd2,3'd1,8'h00,4'd8}, {2'd0,3'd2,8'hFF,4'd8},
    {2'd0,3'd1,8'h00,4'd8}, {2'd2,3'd1,8'h01,4'd8}, {2'd2,3'd2,8'hFD,4'd8}, // R8 flag race
    {2'd0,3'd0,8'h00,4'd0}
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input int r);
    rd_addr = a;
    #0.2;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL R%0d addr=%0d actual=%h expected=%h", r, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input int r);
    #0.2;
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL R%0d irq actual=%b expected=%b", r, irq, exp);
    end
  endtask

  task automatic chk_val(input logic [7:0] act, input logic [7:0] exp, input int r);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d count delta actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] c0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R9: reset state of every register and irq
    for (int a = 0; a < 6; a++) chk(3'(a), 8'h00, 9);
    chk_irq(1'b0, 9);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][16:15])
        2'd0: wr(VEC[i][14:12], VEC[i][11:4]);
        2'd1: repeat (int'(VEC[i][11:4])) @(negedge clk);
        2'd2: chk(VEC[i][14:12], VEC[i][11:4], int'(VEC[i][3:0]));
        default: chk_irq(VEC[i][4], int'(VEC[i][3:0]));
      endcase
    end

    // R4: divide-by-12 rate over 48 clocks
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h08);
    rd_addr = 3'd2; #0.2; c0 = rd_data;
    repeat (48) @(negedge clk);
    rd_addr = 3'd2; #0.2;
    chk_val(rd_data - c0, 8'd4, 4);

    // R4: external clock divided by 8, 16 rising edges in 64 clocks
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h0A);
    repeat (4) @(negedge clk);
    rd_addr = 3'd2; #0.2; c0 = rd_data;
    repeat (64) @(negedge clk);
    rd_addr = 3'd2; #0.2;
    chk_val(rd_data - c0, 8'd2, 4);

    // R9: reset in the middle of activity
    wr(3'd4, 8'h55);
    wr(3'd0, 8'hA9);
    wr(3'd1, 8'h03);
    chk_irq(1'b1, 6);
    rst_n = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 6; a++) chk(3'(a), 8'h00, 9);
    chk_irq(1'b0, 9);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(3'd2, 8'h00, 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule